// File: doc/BRIEF.md
# Remote Read Unrolling Backend

This block sits at the edge of a manycore die, next to the network router. It takes one remote read request from a core-side frontend, and that request may span many cache blocks. The block splits it into a stream of single-block network requests and tags each one with a transfer identifier and a block offset. It then collects the replies, which may come back in any order, and writes each reply's payload into local memory at its final location. When the last block of a transfer has landed, it returns a single completion packet to the frontend that asked for the data.

Up to eight transfers can be outstanding at once. A small table keeps, for each live transfer, the replies still owed, the local destination base and the frontend's identifier. When the table is full, new requests wait. A reply that names a transfer that is not live is thrown away and latches an error flag. The network, the memory and the on-chip completion channel are all plain valid/ready ports.

Top module: `rread_backend`

## Requirements
- R1: After reset, `req_ready` is 1 and `net_valid`, `mem_valid`, `cpl_valid` and `err_flag` are 0.
- R2: An accepted request with length L bytes produces exactly ceil(L/64) network requests, or one request when L is 0. `net_valid` is 0 in the cycle after the last of them is taken.
- R3: Network request k of a transfer (k from 0) carries address `req_raddr + 64*k`, `net_off = k` and the same `net_xid` as the transfer's other requests. Requests go out in increasing k. While `net_ready` is 0, the offered request is held unchanged.
- R4: A reply whose `rpl_xid` names a live transfer drives, in the same cycle, `mem_valid` with `mem_addr = base + 64*rpl_off` and `mem_data = rpl_data`, where base is the `req_laddr` of that transfer.
- R5: The completion for a transfer is raised only in the cycle after its last reply is accepted. It is raised exactly once, with `cpl_dst` equal to the request's `req_src` and `cpl_xid` equal to the transfer's identifier.
- R6: Replies of one transfer are accepted in any order of offsets, and each one is written to its own offset-derived address.
- R7: Up to 8 transfers are outstanding. A new transfer takes the lowest free identifier from 0 to 7. With all 8 live, `req_ready` is 0. An identifier freed by a completion is reused by the next request.
- R8: A reply whose `rpl_xid` is not live is accepted (`rpl_ready` 1) without any memory write. `err_flag` becomes 1 on the next cycle and stays 1 until reset.
- R9: While `cpl_valid` is 1 and `cpl_ready` is 0, the completion's fields stay stable and replies to live transfers are not accepted.
- R10: While `mem_ready` is 0, a reply to a live transfer is not accepted and its memory write stays offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered by a frontend |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_raddr | input | ADDR_W | Remote start address |
| req_laddr | input | ADDR_W | Local destination base address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_src | input | SRC_W | Identifier of the requesting frontend |
| net_valid | output | 1 | Single-block request offered to the network |
| net_ready | input | 1 | Network takes the request |
| net_addr | output | ADDR_W | Remote address of this block |
| net_xid | output | XID_W | Transfer identifier |
| net_off | output | CNT_W | Block offset within the transfer |
| rpl_valid | input | 1 | Reply from the network is present |
| rpl_ready | output | 1 | Reply consumed this cycle |
| rpl_xid | input | XID_W | Transfer identifier of the reply |
| rpl_off | input | CNT_W | Block offset of the reply |
| rpl_data | input | DATA_W | Reply payload |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Local write address |
| mem_data | output | DATA_W | Write data |
| cpl_valid | output | 1 | Completion packet offered |
| cpl_ready | input | 1 | On-chip network takes the completion |
| cpl_dst | output | SRC_W | Frontend the completion goes to |
| cpl_xid | output | XID_W | Transfer that finished |
| err_flag | output | 1 | Sticky flag for replies to non-live transfers |

## Verification
The bench aims at the length edges (0, exactly 64, 65 and long multi-block reads). A wrong rounding there would issue one request too many or too few, and the transfer would then hang or finish early. Replies are shuffled before they are returned, so a design that assumes in-order arrival would write to the wrong address or complete on the wrong reply. The bench fills all eight table slots, then frees one from the middle. A design with a faulty full check or faulty lowest-free reuse would then accept a ninth request or hand out the wrong identifier. It also stalls the completion channel and the memory port in turn, and sends a reply to a dead identifier. A design that dropped a completion, wrote memory while stalled, or failed to latch the error would show it at the ports.

// File: rtl/rread_pkg.sv
package rread_pkg;
    localparam int BLK_LOG2  = 6;
    localparam int BLK_BYTES = 1 << BLK_LOG2;
endpackage

// File: rtl/rread_table.sv
module rread_table #(
    parameter int N_XFER = 8,
    parameter int XID_W  = 3,
    parameter int CNT_W  = 11,
    parameter int ADDR_W = 32,
    parameter int SRC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [CNT_W-1:0]  alloc_cnt,
    input  logic [ADDR_W-1:0] alloc_base,
    input  logic [SRC_W-1:0]  alloc_src,
    output logic              free_avail,
    output logic [XID_W-1:0]  alloc_id,
    input  logic [XID_W-1:0]  lk_id,
    output logic              lk_active,
    output logic [ADDR_W-1:0] lk_base,
    output logic [SRC_W-1:0]  lk_src,
    output logic              lk_last,
    input  logic              dec_en
);
    typedef struct packed {
        logic              act;
        logic [CNT_W-1:0]  rem;
        logic [ADDR_W-1:0] base;
        logic [SRC_W-1:0]  src;
    } slot_t;

    slot_t slot_d [N_XFER];
    slot_t slot_q [N_XFER];

    // lowest free slot
    always_comb begin
        free_avail = 1'b0;
        alloc_id   = '0;
        for (int i = N_XFER - 1; i >= 0; i--) begin
            if (!slot_q[i].act) begin
                free_avail = 1'b1;
                alloc_id   = XID_W'(i);
            end
        end
    end

    // lookup for the reply path
    always_comb begin
        lk_active = 1'b0;
        lk_base   = '0;
        lk_src    = '0;
        lk_last   = 1'b0;
        if (int'(lk_id) < N_XFER) begin
            lk_active = slot_q[lk_id].act;
            lk_base   = slot_q[lk_id].base;
            lk_src    = slot_q[lk_id].src;
            lk_last   = (slot_q[lk_id].rem == CNT_W'(1));
        end
    end

    always_comb begin
        for (int i = 0; i < N_XFER; i++) slot_d[i] = slot_q[i];
        if (dec_en && int'(lk_id) < N_XFER) begin
            if (slot_q[lk_id].rem == CNT_W'(1)) begin
                slot_d[lk_id].act = 1'b0;
                slot_d[lk_id].rem = '0;
            end else begin
                slot_d[lk_id].rem = slot_q[lk_id].rem - CNT_W'(1);
            end
        end
        if (alloc_en) begin
            slot_d[alloc_id].act  = 1'b1;
            slot_d[alloc_id].rem  = alloc_cnt;
            slot_d[alloc_id].base = alloc_base;
            slot_d[alloc_id].src  = alloc_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_XFER; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_XFER; i++) slot_q[i] <= slot_d[i];
        end
    end

    // R4
    dec_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> lk_active);
    // R7
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> free_avail);
endmodule

// File: rtl/rread_unroll.sv
module rread_unroll
    import rread_pkg::*;
#(
    parameter int XID_W  = 3,
    parameter int CNT_W  = 11,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_raddr,
    input  logic [XID_W-1:0]  start_xid,
    input  logic [CNT_W-1:0]  start_nblk,
    output logic              busy,
    output logic              net_valid,
    input  logic              net_ready,
    output logic [ADDR_W-1:0] net_addr,
    output logic [XID_W-1:0]  net_xid,
    output logic [CNT_W-1:0]  net_off
);
    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] raddr;
        logic [XID_W-1:0]  xid;
        logic [CNT_W-1:0]  nblk;
        logic [CNT_W-1:0]  idx;
    } walk_t;

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d = walk_q;
        if (start) begin
            walk_d.busy  = 1'b1;
            walk_d.raddr = start_raddr;
            walk_d.xid   = start_xid;
            walk_d.nblk  = start_nblk;
            walk_d.idx   = '0;
        end else if (walk_q.busy && net_ready) begin
            if (walk_q.idx == walk_q.nblk - CNT_W'(1)) walk_d.busy = 1'b0;
            else walk_d.idx = walk_q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign busy      = walk_q.busy;
    assign net_valid = walk_q.busy;
    assign net_addr  = walk_q.raddr + (ADDR_W'(walk_q.idx) << BLK_LOG2);
    assign net_xid   = walk_q.xid;
    assign net_off   = walk_q.idx;

    // R3
    net_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (net_valid && !net_ready) |=> (net_valid && $stable(net_addr)
                                       && $stable(net_off) && $stable(net_xid)));
    // R3
    net_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (net_valid && net_ready) |=> (!net_valid || net_off == $past(net_off) + CNT_W'(1)));
endmodule

// File: rtl/rread_collect.sv
module rread_collect
    import rread_pkg::*;
#(
    parameter int XID_W  = 3,
    parameter int CNT_W  = 11,
    parameter int ADDR_W = 32,
    parameter int SRC_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rpl_valid,
    output logic              rpl_ready,
    input  logic [XID_W-1:0]  rpl_xid,
    input  logic [CNT_W-1:0]  rpl_off,
    input  logic [DATA_W-1:0] rpl_data,
    output logic [XID_W-1:0]  lk_id,
    input  logic              lk_active,
    input  logic [ADDR_W-1:0] lk_base,
    input  logic [SRC_W-1:0]  lk_src,
    input  logic              lk_last,
    output logic              dec_en,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [SRC_W-1:0]  cpl_dst,
    output logic [XID_W-1:0]  cpl_xid,
    output logic              err_flag
);
    typedef struct packed {
        logic             cvld;
        logic [SRC_W-1:0] cdst;
        logic [XID_W-1:0] cxid;
        logic             err;
    } coll_t;

    coll_t coll_d, coll_q;
    logic  slot_go;

    assign lk_id     = rpl_xid;
    assign slot_go   = !coll_q.cvld || cpl_ready;
    assign mem_valid = rpl_valid && lk_active && slot_go;
    assign mem_addr  = lk_base + (ADDR_W'(rpl_off) << BLK_LOG2);
    assign mem_data  = rpl_data;
    assign rpl_ready = lk_active ? (mem_ready && slot_go) : 1'b1;
    assign dec_en    = mem_valid && mem_ready;

    always_comb begin
        coll_d = coll_q;
        if (cpl_ready) coll_d.cvld = 1'b0;
        if (dec_en && lk_last) begin
            coll_d.cvld = 1'b1;
            coll_d.cdst = lk_src;
            coll_d.cxid = rpl_xid;
        end
        if (rpl_valid && !lk_active) coll_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) coll_q <= '0;
        else        coll_q <= coll_d;
    end

    assign cpl_valid = coll_q.cvld;
    assign cpl_dst   = coll_q.cdst;
    assign cpl_xid   = coll_q.cxid;
    assign err_flag  = coll_q.err;

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    // R8
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpl_valid && !lk_active) |-> (rpl_ready && !mem_valid));
    // R9
    cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_dst) && $stable(cpl_xid)));
endmodule

// File: rtl/rread_backend.sv
module rread_backend
    import rread_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int SRC_W  = 4,
    parameter int DATA_W = 64,
    parameter int N_XFER = 8,
    localparam int XID_W = $clog2(N_XFER),
    localparam int CNT_W = LEN_W - BLK_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_raddr,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [SRC_W-1:0]  req_src,
    output logic              net_valid,
    input  logic              net_ready,
    output logic [ADDR_W-1:0] net_addr,
    output logic [XID_W-1:0]  net_xid,
    output logic [CNT_W-1:0]  net_off,
    input  logic              rpl_valid,
    output logic              rpl_ready,
    input  logic [XID_W-1:0]  rpl_xid,
    input  logic [CNT_W-1:0]  rpl_off,
    input  logic [DATA_W-1:0] rpl_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [SRC_W-1:0]  cpl_dst,
    output logic [XID_W-1:0]  cpl_xid,
    output logic              err_flag
);
    logic              free_avail, walk_busy, take;
    logic [XID_W-1:0]  new_id, lk_id;
    logic [LEN_W:0]    len_sum;
    logic [CNT_W-1:0]  blk_cnt;
    logic              lk_active, lk_last, dec_en;
    logic [ADDR_W-1:0] lk_base;
    logic [SRC_W-1:0]  lk_src;

    assign len_sum   = {1'b0, req_len} + (LEN_W + 1)'(BLK_BYTES - 1);
    assign blk_cnt   = (req_len == '0) ? CNT_W'(1) : CNT_W'(len_sum >> BLK_LOG2);
    assign req_ready = free_avail && !walk_busy;
    assign take      = req_valid && req_ready;

    rread_table #(
        .N_XFER(N_XFER), .XID_W(XID_W), .CNT_W(CNT_W),
        .ADDR_W(ADDR_W), .SRC_W(SRC_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (take),
        .alloc_cnt  (blk_cnt),
        .alloc_base (req_laddr),
        .alloc_src  (req_src),
        .free_avail (free_avail),
        .alloc_id   (new_id),
        .lk_id      (lk_id),
        .lk_active  (lk_active),
        .lk_base    (lk_base),
        .lk_src     (lk_src),
        .lk_last    (lk_last),
        .dec_en     (dec_en)
    );

    rread_unroll #(
        .XID_W(XID_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_unroll (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (take),
        .start_raddr (req_raddr),
        .start_xid   (new_id),
        .start_nblk  (blk_cnt),
        .busy        (walk_busy),
        .net_valid   (net_valid),
        .net_ready   (net_ready),
        .net_addr    (net_addr),
        .net_xid     (net_xid),
        .net_off     (net_off)
    );

    rread_collect #(
        .XID_W(XID_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
        .SRC_W(SRC_W), .DATA_W(DATA_W)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .rpl_valid (rpl_valid),
        .rpl_ready (rpl_ready),
        .rpl_xid   (rpl_xid),
        .rpl_off   (rpl_off),
        .rpl_data  (rpl_data),
        .lk_id     (lk_id),
        .lk_active (lk_active),
        .lk_base   (lk_base),
        .lk_src    (lk_src),
        .lk_last   (lk_last),
        .dec_en    (dec_en),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .cpl_valid (cpl_valid),
        .cpl_ready (cpl_ready),
        .cpl_dst   (cpl_dst),
        .cpl_xid   (cpl_xid),
        .err_flag  (err_flag)
    );

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> net_valid);
endmodule

// File: tb/rread_backend_test.sv
module rread_backend_test;
    localparam int CNT_W = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_raddr = '0, req_laddr = '0;
    logic [15:0] req_len = '0;
    logic [3:0]  req_src = '0;
    logic        net_valid, net_ready = 1'b0;
    logic [31:0] net_addr;
    logic [2:0]  net_xid;
    logic [CNT_W-1:0] net_off;
    logic        rpl_valid = 1'b0, rpl_ready;
    logic [2:0]  rpl_xid = '0;
    logic [CNT_W-1:0] rpl_off = '0;
    logic [63:0] rpl_data = '0;
    logic        mem_valid, mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [63:0] mem_data;
    logic        cpl_valid, cpl_ready = 1'b1;
    logic [3:0]  cpl_dst;
    logic [2:0]  cpl_xid;
    logic        err_flag;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [31:0] base_of [8];
    logic [3:0]  src_of  [8];

    always #10 clk = ~clk;

    rread_backend uut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nblk(input int len);
        return (len == 0) ? 1 : (len + 63) / 64;
    endfunction

    task automatic do_request(input logic [31:0] ra, input logic [31:0] la,
                              input logic [15:0] len, input logic [3:0] src);
        @(negedge clk);
        req_raddr = ra; req_laddr = la; req_len = len; req_src = src; req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // R2 R3: capture the unrolled stream and check it
    task automatic collect_net(input logic [31:0] ra, input int len, output logic [2:0] xid);
        int n = nblk(len);
        int k = 0;
        xid = '0;
        while (k < n) begin
            @(negedge clk);
            net_ready = ($urandom % 3) != 0;
            #1;
            chk(net_valid == 1'b1, "R2 request stream present", 64'(net_valid), 64'd1);
            if (net_valid && net_ready) begin
                chk(net_addr == ra + 32'(k * 64), "R3 block address", 64'(net_addr), 64'(ra + 32'(k * 64)));
                chk(int'(net_off) == k, "R3 block offset", 64'(net_off), 64'(k));
                if (k == 0) xid = net_xid;
                else chk(net_xid == xid, "R3 same xid", 64'(net_xid), 64'(xid));
                k++;
            end
        end
        @(negedge clk);
        net_ready = 1'b0;
        #1;
        chk(net_valid == 1'b0, "R2 request count", 64'(net_valid), 64'd0);
    endtask

    task automatic send_reply(input logic [2:0] xid, input int off, input bit live, input bit last);
        logic [63:0] d = {$urandom, $urandom};
        logic [31:0] ea = base_of[xid] + 32'(off * 64);
        @(negedge clk);
        rpl_valid = 1'b1; rpl_xid = xid; rpl_off = CNT_W'(off); rpl_data = d; mem_ready = 1'b1;
        #1;
        chk(cpl_valid == 1'b0, "R5 no early completion", 64'(cpl_valid), 64'd0);
        if (live) begin
            chk(mem_valid && rpl_ready, "R4 write offered", 64'({mem_valid, rpl_ready}), 64'h3);
            chk(mem_addr == ea, "R4 R6 write address", 64'(mem_addr), 64'(ea));
            chk(mem_data == d, "R4 write data", mem_data, d);
        end else begin
            chk(rpl_ready && !mem_valid, "R8 dropped", 64'({rpl_ready, mem_valid}), 64'h2);
        end
        @(posedge clk); #1;
        rpl_valid = 1'b0;
        if (last) begin
            @(negedge clk); #1;
            chk(cpl_valid == 1'b1, "R5 completion raised", 64'(cpl_valid), 64'd1);
            chk(cpl_dst == src_of[xid], "R5 completion dest", 64'(cpl_dst), 64'(src_of[xid]));
            chk(cpl_xid == xid, "R5 completion xid", 64'(cpl_xid), 64'(xid));
            @(negedge clk); #1;
            chk(cpl_valid == 1'b0, "R5 single completion", 64'(cpl_valid), 64'd0);
        end
    endtask

    task automatic full_xfer(input logic [31:0] ra, input logic [31:0] la, input int len, input logic [3:0] src);
        logic [2:0] x;
        int n = nblk(len);
        int order [64];
        do_request(ra, la, 16'(len), src);
        collect_net(ra, len, x);
        base_of[x] = la; src_of[x] = src;
        for (int i = 0; i < n; i++) order[i] = i;
        for (int i = n - 1; i > 0; i--) begin
            int j = int'($urandom % (i + 1));
            int t = order[i];
            order[i] = order[j]; order[j] = t;
        end
        for (int i = 0; i < n; i++) send_reply(x, order[i], 1'b1, i == n - 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [2:0] x;
        int unused_seed;
        unused_seed = int'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // R1
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        chk({net_valid, mem_valid, cpl_valid, err_flag} == 4'b0, "R1 outputs idle",
            64'({net_valid, mem_valid, cpl_valid, err_flag}), 64'd0);

        // R2 length edges, R6 shuffled replies
        full_xfer(32'h1000_0000, 32'h0000_4000, 0, 4'd3);
        full_xfer(32'h1000_0040, 32'h0000_8000, 64, 4'd5);
        full_xfer(32'h2000_0000, 32'h0001_0000, 65, 4'd9);
        full_xfer(32'h3000_0100, 32'h0002_0000, 640, 4'd1);
        for (int r = 0; r < 12; r++)
            full_xfer($urandom, $urandom, int'($urandom % 700), 4'($urandom));

        // R7 fill the table
        for (int i = 0; i < 8; i++) begin
            do_request(32'h5000_0000 + 32'(i * 4096), 32'h6000_0000 + 32'(i * 256), 16'd1, 4'(i + 2));
            collect_net(32'h5000_0000 + 32'(i * 4096), 1, x);
            chk(x == 3'(i), "R7 lowest free xid", 64'(x), 64'(i));
            base_of[x] = 32'h6000_0000 + 32'(i * 256); src_of[x] = 4'(i + 2);
        end
        @(negedge clk);
        req_valid = 1'b1; req_len = 16'd1;
        for (int c = 0; c < 3; c++) begin
            #1; chk(req_ready == 1'b0, "R7 full back-pressure", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        send_reply(3'd5, 0, 1'b1, 1'b1);
        do_request(32'h7000_0000, 32'h7100_0000, 16'd64, 4'd12);
        collect_net(32'h7000_0000, 64, x);
        chk(x == 3'd5, "R7 freed xid reused", 64'(x), 64'd5);
        base_of[5] = 32'h7100_0000; src_of[5] = 4'd12;
        for (int i = 0; i < 8; i++) send_reply(3'(i), 0, 1'b1, 1'b1);

        // R9 completion stall, R10 memory stall
        do_request(32'h8000_0000, 32'h8100_0000, 16'd128, 4'd7);
        collect_net(32'h8000_0000, 128, x);
        base_of[x] = 32'h8100_0000; src_of[x] = 4'd7;
        send_reply(x, 1, 1'b1, 1'b0);
        cpl_ready = 1'b0;
        send_reply(x, 0, 1'b1, 1'b0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1;
            chk(cpl_valid && cpl_dst == 4'd7, "R9 completion held",
                64'({cpl_valid, cpl_dst}), 64'({1'b1, 4'd7}));
        end
        do_request(32'h9000_0000, 32'h9100_0000, 16'd10, 4'd11);
        begin
            logic [2:0] y;
            collect_net(32'h9000_0000, 10, y);
            base_of[y] = 32'h9100_0000; src_of[y] = 4'd11;
            @(negedge clk);
            rpl_valid = 1'b1; rpl_xid = y; rpl_off = '0; rpl_data = 64'hA5A5_0000_1234_5678;
            #1;
            chk(!rpl_ready && !mem_valid, "R9 reply stalled by completion",
                64'({rpl_ready, mem_valid}), 64'd0);
            @(negedge clk);
            cpl_ready = 1'b1; mem_ready = 1'b0;
            #1;
            chk(mem_valid && !rpl_ready, "R10 memory stall", 64'({mem_valid, rpl_ready}), 64'h2);
            @(negedge clk);
            mem_ready = 1'b1;
            #1;
            chk(mem_valid && rpl_ready && mem_addr == 32'h9100_0000, "R10 stall released",
                64'(mem_addr), 64'h9100_0000);
            @(posedge clk); #1;
            rpl_valid = 1'b0;
            @(negedge clk); #1;
            chk(cpl_valid && cpl_xid == y && cpl_dst == 4'd11, "R5 completion after stall",
                64'({cpl_valid, cpl_dst, cpl_xid}), 64'({1'b1, 4'd11, y}));
        end

        // R8 reply to a dead transfer
        @(negedge clk); #1;
        chk(err_flag == 1'b0, "R8 flag clear before", 64'(err_flag), 64'd0);
        send_reply(3'd2, 0, 1'b0, 1'b0);
        @(negedge clk); #1;
        chk(err_flag == 1'b1, "R8 flag set", 64'(err_flag), 64'd1);
        full_xfer(32'hA000_0000, 32'hA100_0000, 200, 4'd4);
        chk(err_flag == 1'b1, "R8 flag sticky", 64'(err_flag), 64'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule